// File: doc/BRIEF.md
# SD Command Token Issue Engine

The block turns a 6-bit command index and a 32-bit argument into the 48-bit command token of an SD/MMC card bus. It computes the CRC7 field in logic and shows the assembled token to the host as three 16-bit words. The words follow the index and argument inputs, so software can read back the exact token before it commits to sending it.

A fire strobe starts a transfer. The block captures the token, the timeout setting and a parity tag, then shifts the token out MSB-first on the single command line, one bit per card-clock tick. It then releases the line and waits for the card's response start bit, a low level. If that bit arrives inside the timeout window, the block sets a response-ready flag. If it does not, the block sets a response-timeout flag. In both cases the block returns to idle and copies the captured parity tag into the status word. Software can therefore tell a fresh completion from a stale one. Card clock generation is outside the block: a one-cycle tick input marks each falling card-clock edge.

Top module: `sdcmd_issuer`

## Requirements
- R1: Bits [15:8] of `tok_word3` equal 0x40 OR the command index: a start bit 0, then a transmission bit 1, then the six index bits.
- R2: The argument occupies the token most significant byte first. `tok_word3[7:0]` holds arg[31:24], `tok_word2` holds arg[23:8] and `tok_word1[15:8]` holds arg[7:0].
- R3: `tok_word1[7:0]` is the CRC7 shifted left by one, with a 1 in bit 0. The CRC7 uses x^7+x^3+1, starts from zero and runs MSB-first over the first five token bytes. Index 0 with argument 0 gives 0x95, and index 8 with argument 0x1AA gives 0x87.
- R4: A fire pulse while idle starts a transfer. The 48 captured token bits then appear on `cmd_out`, MSB first, one bit per tick. `cmd_oe` stays high for the whole transfer.
- R5: A fire pulse while a transfer is in progress is ignored. The token on the line, the timeout and the parity tag are not changed.
- R6: After the last token bit, `cmd_oe` goes low. When `cmd_in` is sampled low on a tick, status bit 1 (response ready) is set and the block returns to idle.
- R7: The response window lasts `tmo_units` × 2^TMO_SCALE_LOG2 ticks. If `cmd_in` is still high on the last tick of the window, status bit 2 (response timeout) is set and the block returns to idle. A low level on that last tick still counts as a response.
- R8: A `tmo_units` value of 0 selects the default window of 0xFFF units.
- R9: Status bit 15 takes the `fire_par` value captured at the accepted fire, and changes only at completion. Bits 1 and 2 are cleared when a fire is accepted. Status bits 14:3 always read 0.
- R10: After reset, status reads 0x0001 (bit 0 means idle). While idle, the block drives the command line high with `cmd_oe` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| tok_word3 | output | 16 | Token bytes 0 and 1 |
| tok_word2 | output | 16 | Token bytes 2 and 3 |
| tok_word1 | output | 16 | Token byte 4 and the CRC/end byte |
| fire | input | 1 | Start strobe, one cycle |
| fire_par | input | 1 | Parity tag echoed at completion |
| tmo_units | input | 12 | Response window in units of 2^TMO_SCALE_LOG2 ticks, 0 = default |
| card_tick | input | 1 | Falling card-clock edge enable |
| cmd_in | input | 1 | Sampled command line |
| cmd_out | output | 1 | Driven command line value |
| cmd_oe | output | 1 | Command line drive enable |
| status | output | 16 | Bit 15 parity echo, bit 2 timeout, bit 1 response ready, bit 0 idle |

## Verification
The bench builds the block with TMO_SCALE_LOG2 = 2, so one timeout unit is four ticks. With this setting, even the default window of 0xFFF units (16380 ticks) fits in one run at one tick per cycle, and R8 can be checked to the exact tick. The token words are swept over all 64 indices against several argument patterns. Transfers run with both a dense and a sparse tick pattern, with responses placed just inside and just outside the window edge.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
    localparam int TOKEN_BITS = 48;
    localparam int CRC_SPAN   = 40;

    localparam int STAT_IDLE = 0;
    localparam int STAT_RDY  = 1;
    localparam int STAT_TMO  = 2;
    localparam int STAT_PAR  = 15;

    typedef enum logic [1:0] {
        ISS_IDLE = 2'd0,
        ISS_SEND = 2'd1,
        ISS_WAIT = 2'd2
    } iss_state_e;
endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 #(
    parameter int DATA_BITS = 40
) (
    input  logic [DATA_BITS-1:0] data_i,
    output logic [6:0]           crc_o
);
    logic [6:0] chain [0:DATA_BITS];

    assign chain[0] = 7'd0;

    for (genvar gi = 0; gi < DATA_BITS; gi++) begin : g_stage
        logic fb;
        assign fb = data_i[DATA_BITS-1-gi] ^ chain[gi][6];
        assign chain[gi+1] = {chain[gi][5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end

    assign crc_o = chain[DATA_BITS];
endmodule

// File: rtl/sdcmd_token_build.sv
module sdcmd_token_build
    import sdcmd_pkg::*;
(
    input  logic [5:0]            index_i,
    input  logic [31:0]           arg_i,
    output logic [TOKEN_BITS-1:0] token_o,
    output logic [15:0]           word3_o,
    output logic [15:0]           word2_o,
    output logic [15:0]           word1_o
);
    logic [CRC_SPAN-1:0] head;
    logic [6:0]          crc;

    assign head = {2'b01, index_i, arg_i};

    sdcmd_crc7 #(.DATA_BITS(CRC_SPAN)) u_crc (
        .data_i (head),
        .crc_o  (crc)
    );

    assign token_o = {head, crc, 1'b1};
    assign word3_o = token_o[47:32];
    assign word2_o = token_o[31:16];
    assign word1_o = token_o[15:0];
endmodule

// File: rtl/sdcmd_shifter.sv
module sdcmd_shifter #(
    parameter int BITS = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [BITS-1:0] load_val_i,
    input  logic            tick_i,
    output logic            bit_o,
    output logic            done_o
);
    localparam int CNT_W = $clog2(BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

    typedef struct packed {
        logic [BITS-1:0]  shreg;
        logic [CNT_W-1:0] cnt;
        logic             active;
    } shift_t;

    shift_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.shreg  = load_val_i;
            s_d.cnt    = '0;
            s_d.active = 1'b1;
        end else if (s_q.active && tick_i) begin
            if (s_q.cnt == LAST) begin
                s_d.active = 1'b0;
            end else begin
                s_d.shreg = {s_q.shreg[BITS-2:0], 1'b0};
                s_d.cnt   = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bit_o  = s_q.shreg[BITS-1];
    assign done_o = s_q.active && tick_i && (s_q.cnt == LAST);

    a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.active |-> (s_q.cnt <= LAST));

    a_r5_no_reload_while_active: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !s_q.active);
endmodule

// File: rtl/sdcmd_resp_timer.sv
module sdcmd_resp_timer #(
    parameter int TMO_W       = 12,
    parameter int SCALE_LOG2  = 4,
    parameter logic [TMO_W-1:0] DEFAULT_UNITS = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [TMO_W-1:0] units_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             line_i,
    output logic             hit_o,
    output logic             expire_o
);
    localparam int CW = TMO_W + SCALE_LOG2;

    typedef struct packed {
        logic [CW-1:0] limit;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;
    logic [TMO_W-1:0] units_eff;

    always_comb begin
        units_eff = (units_i == '0) ? DEFAULT_UNITS : units_i;
        t_d = t_q;
        if (arm_i) begin
            t_d.limit = CW'(units_eff) << SCALE_LOG2;
            t_d.cnt   = '0;
        end else if (run_i && tick_i) begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign hit_o    = run_i && tick_i && !line_i;
    assign expire_o = run_i && tick_i && line_i && (t_q.cnt == t_q.limit - 1'b1);

    a_r7_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (t_q.cnt < t_q.limit));

    a_r8_window_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (t_q.limit != '0));
endmodule

// File: rtl/sdcmd_issuer.sv
module sdcmd_issuer
    import sdcmd_pkg::*;
#(
    parameter int TMO_W          = 12,
    parameter int TMO_SCALE_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [5:0]       cmd_index,
    input  logic [31:0]      cmd_arg,
    output logic [15:0]      tok_word3,
    output logic [15:0]      tok_word2,
    output logic [15:0]      tok_word1,
    input  logic             fire,
    input  logic             fire_par,
    input  logic [TMO_W-1:0] tmo_units,
    input  logic             card_tick,
    input  logic             cmd_in,
    output logic             cmd_out,
    output logic             cmd_oe,
    output logic [15:0]      status
);
    typedef struct packed {
        iss_state_e st;
        logic       fpar;
        logic       par;
        logic       rdy;
        logic       tmo;
    } iss_t;

    iss_t r_d, r_q;

    logic [TOKEN_BITS-1:0] token;
    logic accept, shift_bit, shift_done, hit, expire, finish;

    sdcmd_token_build u_build (
        .index_i (cmd_index),
        .arg_i   (cmd_arg),
        .token_o (token),
        .word3_o (tok_word3),
        .word2_o (tok_word2),
        .word1_o (tok_word1)
    );

    assign accept = fire && (r_q.st == ISS_IDLE);

    sdcmd_shifter #(.BITS(TOKEN_BITS)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .load_val_i (token),
        .tick_i     (card_tick),
        .bit_o      (shift_bit),
        .done_o     (shift_done)
    );

    sdcmd_resp_timer #(
        .TMO_W      (TMO_W),
        .SCALE_LOG2 (TMO_SCALE_LOG2)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (accept),
        .units_i  (tmo_units),
        .run_i    (r_q.st == ISS_WAIT),
        .tick_i   (card_tick),
        .line_i   (cmd_in),
        .hit_o    (hit),
        .expire_o (expire)
    );

    assign finish = hit || expire;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ISS_IDLE: if (accept) begin
                r_d.st   = ISS_SEND;
                r_d.fpar = fire_par;
                r_d.rdy  = 1'b0;
                r_d.tmo  = 1'b0;
            end
            ISS_SEND: if (shift_done) r_d.st = ISS_WAIT;
            ISS_WAIT: if (hit) begin
                r_d.rdy = 1'b1;
                r_d.par = r_q.fpar;
                r_d.st  = ISS_IDLE;
            end else if (expire) begin
                r_d.tmo = 1'b1;
                r_d.par = r_q.fpar;
                r_d.st  = ISS_IDLE;
            end
            default: r_d.st = ISS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ISS_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign cmd_oe  = (r_q.st != ISS_WAIT);
    assign cmd_out = (r_q.st == ISS_SEND) ? shift_bit : 1'b1;

    always_comb begin
        status            = '0;
        status[STAT_IDLE] = (r_q.st == ISS_IDLE);
        status[STAT_RDY]  = r_q.rdy;
        status[STAT_TMO]  = r_q.tmo;
        status[STAT_PAR]  = r_q.par;
    end

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.rdy && r_q.tmo));

    a_r9_parity_held_until_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ISS_IDLE && !finish) |=> $stable(r_q.par));

    a_r6_ready_after_low_line: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.rdy) |-> !$past(cmd_in));

    a_r10_idle_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
        status[STAT_IDLE] |-> (cmd_oe && cmd_out));
endmodule

// File: tb/sdcmd_issuer_bench.sv
module sdcmd_issuer_bench;
    localparam int SCALE = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic [15:0] tok_word3, tok_word2, tok_word1;
    logic        fire = 1'b0;
    logic        fire_par = 1'b0;
    logic [11:0] tmo_units = '0;
    logic        card_tick = 1'b0;
    logic        cmd_in = 1'b1;
    logic        cmd_out, cmd_oe;
    logic [15:0] status;

    int checks = 0;
    int errors = 0;
    logic last_par = 1'b0;

    always #2 clk = ~clk;

    sdcmd_issuer #(.TMO_W(12), .TMO_SCALE_LOG2(SCALE)) u_sdcmd_issuer (
        .clk(clk), .rst_n(rst_n), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
        .tok_word3(tok_word3), .tok_word2(tok_word2), .tok_word1(tok_word1),
        .fire(fire), .fire_par(fire_par), .tmo_units(tmo_units),
        .card_tick(card_tick), .cmd_in(cmd_in), .cmd_out(cmd_out),
        .cmd_oe(cmd_oe), .status(status)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] crc_ref(input logic [39:0] msg);
        logic [7:0] c;
        logic [7:0] d;
        c = 8'd0;
        for (int b = 0; b < 5; b++) begin
            d = msg[39-8*b -: 8];
            for (int n = 0; n < 8; n++) begin
                c = c << 1;
                if (d[7] ^ c[7]) c = c ^ 8'h09;
                d = d << 1;
            end
        end
        return {c[6:0], 1'b1};
    endfunction

    function automatic logic [47:0] tok_ref(input logic [5:0] idx, input logic [31:0] arg);
        logic [39:0] h;
        h = {8'h40 | {2'b00, idx}, arg};
        return {h, crc_ref(h)};
    endfunction

    task automatic do_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [11:0] tmo,
                          input logic par, input int tdiv, input int resp_after, input bit poke,
                          input string tag);
        logic [47:0] exp_tok;
        logic [47:0] got;
        int nb;
        int wticks;
        int cyc;
        int limit;
        bit exp_ok;
        logic [15:0] exp_stat;
        exp_tok = tok_ref(idx, arg);
        got = '0; nb = 0; wticks = 0; cyc = 0;
        limit = ((tmo == 0) ? 4095 : int'(tmo)) * (1 << SCALE);
        @(negedge clk);
        cmd_index = idx; cmd_arg = arg; tmo_units = tmo; fire_par = par;
        fire = 1'b1; card_tick = 1'b0; cmd_in = 1'b1;
        @(negedge clk);
        fire = 1'b0;
        check(status[0] == 1'b0 && status[2:1] == 2'b00, {tag, " R9 flags cleared, busy"},
              64'(status), 64'(status & 16'h8000));
        check(status[15] == last_par, {tag, " R9 parity not yet updated"},
              64'(status[15]), 64'(last_par));
        while (status[0] == 1'b0 && cyc < 100000) begin
            card_tick = ((cyc % tdiv) == tdiv - 1);
            fire = 1'b0;
            if (poke && cyc == 10) begin
                fire = 1'b1; fire_par = ~par; cmd_index = ~idx; tmo_units = 12'd1;
            end
            cmd_in = 1'b1;
            if (card_tick) begin
                if (cmd_oe) begin
                    got = {got[46:0], cmd_out};
                    nb++;
                end else begin
                    wticks++;
                    if (resp_after >= 0 && wticks == resp_after + 1) cmd_in = 1'b0;
                end
            end
            @(negedge clk);
            cyc++;
        end
        card_tick = 1'b0; cmd_in = 1'b1; fire = 1'b0;
        check(nb == 48, {tag, " R4 bit count"}, 64'(nb), 64'd48);
        check(got == exp_tok, {tag, " R4 serial token"}, 64'(got), 64'(exp_tok));
        exp_ok = (resp_after >= 0) && (resp_after + 1 <= limit);
        exp_stat = {par, 12'd0, ~exp_ok, exp_ok, 1'b1};
        check(status == exp_stat, {tag, exp_ok ? " R6 ready status" : " R7 timeout status"},
              64'(status), 64'(exp_stat));
        check(wticks == (exp_ok ? resp_after + 1 : limit), {tag, " R7 window ticks"},
              64'(wticks), 64'(exp_ok ? resp_after + 1 : limit));
        check(cmd_oe && cmd_out, {tag, " R10 line driven high after finish"},
              64'({cmd_oe, cmd_out}), 64'd3);
        last_par = par;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(status == 16'h0001, "R10 reset status", 64'(status), 64'h0001);
        check(cmd_oe && cmd_out, "R10 reset line high", 64'({cmd_oe, cmd_out}), 64'd3);

        // R1 R2 R3: word sweep over every index and several arguments
        for (int i = 0; i < 64; i++) begin
            for (int a = 0; a < 4; a++) begin
                logic [31:0] arg;
                logic [47:0] t;
                arg = (a == 0) ? 32'h0 : (a == 1) ? 32'hFFFF_FFFF : (a == 2) ? 32'h0000_01AA : 32'hA5C3_3C5A;
                cmd_index = 6'(i); cmd_arg = arg;
                #1;
                t = tok_ref(6'(i), arg);
                check(tok_word3 == t[47:32], "R1 R2 word3", 64'(tok_word3), 64'(t[47:32]));
                check(tok_word2 == t[31:16], "R2 word2", 64'(tok_word2), 64'(t[31:16]));
                check(tok_word1 == t[15:0], "R3 word1", 64'(tok_word1), 64'(t[15:0]));
            end
        end
        cmd_index = 6'd0; cmd_arg = 32'd0; #1;
        check(tok_word1[7:0] == 8'h95, "R3 vector index0", 64'(tok_word1[7:0]), 64'h95);
        cmd_index = 6'd8; cmd_arg = 32'h1AA; #1;
        check(tok_word1[7:0] == 8'h87, "R3 vector index8", 64'(tok_word1[7:0]), 64'h87);

        do_cmd(6'd0, 32'h0, 12'd5, 1'b1, 1, 3, 1'b0, "dense response");
        do_cmd(6'd8, 32'h1AA, 12'd2, 1'b0, 3, -1, 1'b0, "sparse timeout");
        do_cmd(6'd17, 32'hDEAD_BEEF, 12'd1, 1'b1, 1, 3, 1'b0, "response on last tick");
        do_cmd(6'd24, 32'h1234_5678, 12'd1, 1'b0, 1, 4, 1'b0, "response one tick late");
        do_cmd(6'd55, 32'h0F0F_F0F0, 12'd3, 1'b1, 2, 5, 1'b1, "R5 busy fire ignored");
        do_cmd(6'd63, 32'h8000_0001, 12'd0, 1'b0, 1, -1, 1'b0, "R8 default window");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule